// File: doc/BRIEF.md
# Horizontal Pixel Binner with Output Bit Selection

This block reduces the horizontal resolution of a video line. Every accepted beat carries ten 14-bit pixels side by side. The block adds groups of 1, 2, 5 or 10 neighbouring pixels into one sum. A group never crosses a beat boundary, so one beat yields ten, five, two or one sums. The sums keep their arrival order and are packed into a collection of ten 18-bit lanes. A word is released when all ten lanes are filled, or when the last beat of a line arrives. In the second case the lanes that were not written are zero.

Before the word leaves the block, every 18-bit lane is cut down to 16 bits. A resolution-mode input selects the upper sixteen bits (which scales the sum by one quarter) or the lower sixteen bits (which keeps full precision but can wrap). The line and frame markers pass through the same single register stage as the data, so the three stay aligned at the output.

Top module: `hbin_top`

## Requirements
- R1: While reset is held and on the first edge after it, out_valid, out_line, out_frame and out_data are all zero.
- R2: cfg_bin selects the group size: code 0 = 1, code 1 = 2, code 2 = 5, code 3 = 10. Pixel lane i sits at in_pix[14i+13:14i]. Sum j of a beat is the total of pixels j*F through j*F+F-1.
- R3: With code 0, every pixel reaches its own output lane zero-extended to 18 bits before selection.
- R4: Sums fill output lanes in arrival order, lowest lane first, across successive beats and across idle gaps. A word appears one cycle after the beat that fills its tenth lane.
- R5: With cfg_hi = 1, output lane i (out_data[16i+15:16i]) is bits [17:2] of the 18-bit sum. With cfg_hi = 0 it is bits [15:0]. The mode is taken from the beat that releases the word.
- R6: A beat with in_eol = 1 releases the lanes collected so far with the unused lanes zero, and the next line starts at lane 0. If the same beat also fills the tenth lane, exactly one word is produced.
- R7: A beat is accepted only when in_valid and in_line are both 1. Any other beat adds no sums and produces no output.
- R8: out_line and out_frame equal in_line and in_frame one cycle earlier.
- R9: out_valid rises exactly once for each released word and never rises in any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat valid |
| in_line | input | 1 | Line-valid marker |
| in_frame | input | 1 | Frame-valid marker |
| in_eol | input | 1 | Marks the last beat of a line |
| in_pix | input | 140 | Ten 14-bit pixels, lane 0 in the low bits |
| cfg_bin | input | 2 | Group size code |
| cfg_hi | input | 1 | 1 selects sum bits [17:2], 0 selects bits [15:0] |
| out_valid | output | 1 | Output word valid, one-cycle pulse |
| out_line | output | 1 | Delayed line marker |
| out_frame | output | 1 | Delayed frame marker |
| out_data | output | 160 | Ten 16-bit binned pixels |

## Verification
The collision of interest is a single beat that both fills the tenth lane and carries the end-of-line flag. The fill path and the flush path then want to release a word in the same cycle. The bench provokes this with group size 2, where the flagged second beat of a line completes the word. The scoreboard expects exactly one full word, and any additional pulse counts as an unexpected output. A partial flush, where the flag arrives after only three of ten lanes, is also run. Its result confirms that the leftover lanes are zero and that the following line starts again at lane 0.

// File: rtl/hbin_pkg.sv
`timescale 1ns/1ps
package hbin_pkg;
    localparam int LANES  = 10;
    localparam int PIX_W  = 14;
    localparam int SUM_W  = 18;
    localparam int OUT_W  = 16;
    localparam int CODE_W = 2;
    localparam int NVAR   = 1 << CODE_W;
    localparam int CNT_W  = $clog2(2 * LANES);

    // Group size for each configuration code; every size divides LANES.
    function automatic int factor_of(int code);
        case (code)
            0:       return 1;
            1:       return 2;
            2:       return 5;
            default: return 10;
        endcase
    endfunction
endpackage

// File: rtl/hbin_adder.sv
`timescale 1ns/1ps
module hbin_adder #(
    parameter int LANES  = hbin_pkg::LANES,
    parameter int PIX_W  = hbin_pkg::PIX_W,
    parameter int SUM_W  = hbin_pkg::SUM_W,
    parameter int CODE_W = hbin_pkg::CODE_W,
    parameter int CNT_W  = hbin_pkg::CNT_W
) (
    input  logic [LANES*PIX_W-1:0] pix,
    input  logic [CODE_W-1:0]      code,
    output logic [LANES*SUM_W-1:0] grp,
    output logic [CNT_W-1:0]       n_grp
);
    localparam int NVAR = 1 << CODE_W;

    logic [LANES*SUM_W-1:0] var_sum [NVAR];
    logic [CNT_W-1:0]       var_cnt [NVAR];

    // One adder tree per supported group size; the code picks one.
    for (genvar v = 0; v < NVAR; v++) begin : g_var
        localparam int F = hbin_pkg::factor_of(v);
        localparam int G = LANES / F;
        logic [LANES*SUM_W-1:0] vs;

        always_comb begin
            vs = '0;
            for (int j = 0; j < G; j++) begin
                logic [SUM_W-1:0] acc;
                acc = '0;
                for (int k = 0; k < F; k++) begin
                    acc = acc + SUM_W'(pix[(j*F+k)*PIX_W +: PIX_W]);
                end
                vs[j*SUM_W +: SUM_W] = acc;
            end
        end

        assign var_sum[v] = vs;
        assign var_cnt[v] = CNT_W'(G);
    end

    assign grp   = var_sum[code];
    assign n_grp = var_cnt[code];
endmodule

// File: rtl/hbin_pack.sv
`timescale 1ns/1ps
module hbin_pack #(
    parameter int LANES = hbin_pkg::LANES,
    parameter int SUM_W = hbin_pkg::SUM_W,
    parameter int CNT_W = hbin_pkg::CNT_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   acc,
    input  logic                   eol,
    input  logic                   hi_in,
    input  logic                   line_in,
    input  logic                   frame_in,
    input  logic [LANES*SUM_W-1:0] grp,
    input  logic [CNT_W-1:0]       n_grp,
    output logic [LANES*SUM_W-1:0] word_q,
    output logic                   valid_q,
    output logic                   hi_q,
    output logic                   line_q,
    output logic                   frame_q
);
    localparam int W = LANES * SUM_W;

    typedef struct packed {
        logic [W-1:0]     coll;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     word;
        logic             valid;
        logic             hi;
        logic             line;
        logic             frame;
    } st_t;

    st_t              s_d, s_q;
    logic [W-1:0]     merged;
    logic [CNT_W-1:0] total;

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        s_d.line  = line_in;
        s_d.frame = frame_in;
        merged    = s_q.coll;
        total     = s_q.cnt + n_grp;
        for (int s = 0; s < LANES; s++) begin
            if (s >= int'(s_q.cnt) && s < int'(total)) begin
                merged[s*SUM_W +: SUM_W] = grp[(s - int'(s_q.cnt))*SUM_W +: SUM_W];
            end
        end
        if (acc) begin
            if (int'(total) >= LANES || eol) begin
                s_d.word  = merged;
                s_d.valid = 1'b1;
                s_d.hi    = hi_in;
                s_d.coll  = '0;
                s_d.cnt   = '0;
            end else begin
                s_d.coll = merged;
                s_d.cnt  = total;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign word_q  = s_q.word;
    assign valid_q = s_q.valid;
    assign hi_q    = s_q.hi;
    assign line_q  = s_q.line;
    assign frame_q = s_q.frame;

    AST_CNT_BELOW_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        int'(s_q.cnt) < LANES); // R4
    AST_EMIT_NEEDS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.valid |-> $past(acc)); // R9
    AST_EMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.valid |-> (s_q.cnt == '0)); // R6
    AST_EOL_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && eol) |=> s_q.valid); // R6
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> ($stable(s_q.cnt) && !s_q.valid)); // R7
endmodule

// File: rtl/hbin_select.sv
`timescale 1ns/1ps
module hbin_select #(
    parameter int LANES = hbin_pkg::LANES,
    parameter int SUM_W = hbin_pkg::SUM_W,
    parameter int OUT_W = hbin_pkg::OUT_W
) (
    input  logic [LANES*SUM_W-1:0] word,
    input  logic                   hi,
    output logic [LANES*OUT_W-1:0] data
);
    localparam int SHIFT = SUM_W - OUT_W;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign data[i*OUT_W +: OUT_W] = hi ? word[i*SUM_W + SHIFT +: OUT_W]
                                           : word[i*SUM_W +: OUT_W];
    end
endmodule

// File: rtl/hbin_top.sv
`timescale 1ns/1ps
module hbin_top #(
    parameter int LANES  = hbin_pkg::LANES,
    parameter int PIX_W  = hbin_pkg::PIX_W,
    parameter int SUM_W  = hbin_pkg::SUM_W,
    parameter int OUT_W  = hbin_pkg::OUT_W,
    parameter int CODE_W = hbin_pkg::CODE_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   in_line,
    input  logic                   in_frame,
    input  logic                   in_eol,
    input  logic [LANES*PIX_W-1:0] in_pix,
    input  logic [CODE_W-1:0]      cfg_bin,
    input  logic                   cfg_hi,
    output logic                   out_valid,
    output logic                   out_line,
    output logic                   out_frame,
    output logic [LANES*OUT_W-1:0] out_data
);
    localparam int CNT_W = $clog2(2 * LANES);

    logic                   acc;
    logic [LANES*SUM_W-1:0] grp;
    logic [CNT_W-1:0]       n_grp;
    logic [LANES*SUM_W-1:0] word_q;
    logic                   hi_q;

    assign acc = in_valid && in_line;

    hbin_adder #(.LANES(LANES), .PIX_W(PIX_W), .SUM_W(SUM_W),
                 .CODE_W(CODE_W), .CNT_W(CNT_W)) u_adder (
        .pix(in_pix), .code(cfg_bin), .grp(grp), .n_grp(n_grp));

    hbin_pack #(.LANES(LANES), .SUM_W(SUM_W), .CNT_W(CNT_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .acc(acc), .eol(in_eol), .hi_in(cfg_hi),
        .line_in(in_line), .frame_in(in_frame), .grp(grp), .n_grp(n_grp),
        .word_q(word_q), .valid_q(out_valid), .hi_q(hi_q),
        .line_q(out_line), .frame_q(out_frame));

    hbin_select #(.LANES(LANES), .SUM_W(SUM_W), .OUT_W(OUT_W)) u_select (
        .word(word_q), .hi(hi_q), .data(out_data));

    AST_ACCEPT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && in_line)); // R7
endmodule

// File: tb/hbin_top_bench.sv
`timescale 1ns/1ps
module hbin_top_bench;
    localparam int LANES = 10;
    localparam int PIX_W = 14;
    localparam int OUT_W = 16;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   in_valid = 1'b0, in_line = 1'b0, in_frame = 1'b0, in_eol = 1'b0;
    logic [LANES*PIX_W-1:0] in_pix = '0;
    logic [1:0]             cfg_bin = '0;
    logic                   cfg_hi = 1'b0;
    logic                   out_valid, out_line, out_frame;
    logic [LANES*OUT_W-1:0] out_data;

    hbin_top u_hbin_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_line(in_line),
        .in_frame(in_frame), .in_eol(in_eol), .in_pix(in_pix), .cfg_bin(cfg_bin),
        .cfg_hi(cfg_hi), .out_valid(out_valid), .out_line(out_line),
        .out_frame(out_frame), .out_data(out_data));

    always #2.5 clk = ~clk;

    typedef struct {
        logic [LANES*OUT_W-1:0] data;
        string                  tag;
    } exp_t;

    exp_t expq[$];
    int   n_cmp = 0, n_bad = 0;
    int   mcoll[LANES];
    int   mcnt = 0;
    bit   done = 0;
    logic line_prev, frame_prev;

    function automatic int fac(int code);
        case (code)
            0: return 1;
            1: return 2;
            2: return 5;
            default: return 10;
        endcase
    endfunction

    function automatic int pixval(int base, int i);
        if (base < 0) return 16383;
        return (base * 131 + i * 977 + 7) % 16384;
    endfunction

    // Driver: applies one beat and updates the reference collection.
    task automatic beat(int code, bit hi, int base, bit eol, bit valid, bit line, string tag);
        int p[LANES];
        @(negedge clk);
        for (int i = 0; i < LANES; i++) begin
            p[i] = pixval(base, i);
            in_pix[i*PIX_W +: PIX_W] = PIX_W'(p[i]);
        end
        in_valid = valid; in_line = line; in_frame = 1'b1; in_eol = eol;
        cfg_bin = 2'(code); cfg_hi = hi;
        if (valid && line) begin
            int f;
            f = fac(code);
            for (int j = 0; j < LANES / f; j++) begin
                int s;
                s = 0;
                for (int k = 0; k < f; k++) s += p[j*f + k];
                mcoll[mcnt] = s;
                mcnt++;
            end
            if (mcnt == LANES || eol) begin
                exp_t e;
                for (int l = 0; l < LANES; l++) begin
                    int v;
                    v = (l < mcnt) ? mcoll[l] : 0;
                    e.data[l*OUT_W +: OUT_W] = hi ? OUT_W'((v >> 2) & 16'hFFFF)
                                                  : OUT_W'(v & 16'hFFFF);
                end
                e.tag = tag;
                expq.push_back(e);
                mcnt = 0;
            end
        end
    endtask

    task automatic idle(int n, bit frame);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            in_valid = 1'b0; in_eol = 1'b0; in_line = 1'b0; in_frame = frame;
        end
    endtask

    task automatic check(string tag, logic [LANES*OUT_W-1:0] act, logic [LANES*OUT_W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference for marker delay (R8).
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin line_prev <= 1'b0; frame_prev <= 1'b0; end
        else        begin line_prev <= in_line; frame_prev <= in_frame; end
    end

    // Monitor: compares released words against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R8 line", {159'b0, out_line}, {159'b0, line_prev});
            check("R8 frame", {159'b0, out_frame}, {159'b0, frame_prev});
            if (out_valid) begin
                if (expq.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R9 unexpected word actual=%h expected=none", out_data);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check(e.tag, out_data, e.data);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog R9 actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid", {159'b0, out_valid}, '0);
        check("R1 data", out_data, '0);
        check("R1 markers", {158'b0, out_line, out_frame}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {157'b0, out_valid, out_line, out_frame}, '0);

        // R3: pass-through, low bits
        for (int b = 1; b <= 3; b++) beat(0, 0, b, 0, 1, 1, "R3 pass low");
        idle(2, 1);
        // R5: pass-through, high bits
        for (int b = 4; b <= 5; b++) beat(0, 1, b, 0, 1, 1, "R5 pass high");
        idle(2, 1);
        // R2: pairs over two beats per word
        for (int b = 6; b <= 9; b++) beat(1, 0, b, 0, 1, 1, "R2 pairs");
        beat(1, 0, -1, 0, 1, 1, "R2 pairs max");
        beat(1, 0, -1, 0, 1, 1, "R2 pairs max");
        idle(2, 1);
        // R4: groups of five over five beats
        for (int b = 10; b <= 14; b++) beat(2, 1, b, 0, 1, 1, "R4 fives");
        for (int b = 0; b < 5; b++) beat(2, 1, -1, 0, 1, 1, "R4 fives max");
        idle(2, 1);
        // R5: full-row sums, upper and wrapping lower selection
        for (int b = 0; b < 10; b++) beat(3, 1, -1, 0, 1, 1, "R5 tens high max");
        for (int b = 0; b < 10; b++) beat(3, 0, -1, 0, 1, 1, "R5 tens low wrap");
        idle(2, 0);
        // R6: partial flush, then next line restarts at lane 0
        beat(3, 0, 20, 0, 1, 1, "R6 partial flush");
        beat(3, 0, 21, 0, 1, 1, "R6 partial flush");
        beat(3, 0, 22, 1, 1, 1, "R6 partial flush");
        idle(1, 1);
        beat(1, 1, 23, 0, 1, 1, "R6 fill and flush together");
        beat(1, 1, 24, 1, 1, 1, "R6 fill and flush together");
        idle(1, 1);
        beat(0, 0, 25, 1, 1, 1, "R6 eol on pass beat");
        idle(2, 1);
        // R7: ignored beats between accepted ones
        beat(2, 0, 30, 0, 1, 1, "R7 gated beats");
        beat(2, 0, 31, 0, 1, 1, "R7 gated beats");
        beat(2, 0, -1, 1, 1, 0, "R7 gated beats");
        beat(2, 0, -1, 0, 0, 1, "R7 gated beats");
        idle(3, 0);
        beat(2, 0, 32, 0, 1, 1, "R7 gated beats");
        beat(2, 0, 33, 0, 1, 1, "R7 gated beats");
        beat(2, 0, 34, 0, 1, 1, "R7 gated beats");
        idle(2, 1);
        // R4: idle gaps between beats keep lane order
        for (int b = 40; b < 50; b++) begin
            beat(3, 1, b, 0, 1, 1, "R4 gaps");
            idle(b % 3, 1);
        end
        idle(4, 0);

        done = 1;
        n_cmp++;
        if (expq.size() != 0) begin
            n_bad++;
            $display("FAIL R9 missing words actual=%0d expected=0", expq.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule